// File: doc/BRIEF.md
# Receive-Fill RTS Flow Controller

This block generates the request-to-send pin for automatic hardware flow control of a serial receiver. It watches the current occupancy of the receive FIFO and compares it with a programmable 6-bit threshold. When the fill reaches the threshold, an internal trigger is raised. The trigger is visible only as a status output and never causes an interrupt. In hardware flow-control mode, the trigger withdraws the request to send. The request returns once the fill has drained to four entries below the threshold. Between those two points the pin keeps its state.

In manual mode the pin simply mirrors a software request bit. A threshold below four switches the whole flow-delay mechanism off. In that case the trigger stays low and the pin follows the software bit even when hardware flow control is selected. Both outputs are registered and reflect the inputs sampled at the previous rising clock edge. The pin is active-low: a granted request drives it to 0.

Top module: `rx_flow_rts`

## Requirements
- R1: During and right after reset, `rtsPinN` is 1 (request withdrawn) and `flowTrig` is 0.
- R2: With `flowThresh` >= 4, `flowTrig` is 1 in the cycle after `fifoLevel` >= `flowThresh`, and 0 in the cycle after `fifoLevel` < `flowThresh`.
- R3: With `hwFlowEn`=1 and `flowThresh` >= 4, `rtsPinN` becomes 1 in the cycle after `fifoLevel` >= `flowThresh`.
- R4: With `hwFlowEn`=1 and `flowThresh` >= 4, `rtsPinN` becomes 0 in the cycle after `fifoLevel` + 4 <= `flowThresh`.
- R5: With `hwFlowEn`=1 and `flowThresh` >= 4, a fill strictly between `flowThresh`-4 and `flowThresh` leaves `rtsPinN` unchanged.
- R6: With `flowThresh` < 4, `flowTrig` stays 0 and `rtsPinN` is the inverse of `swRtsReq` (one cycle later), whatever `hwFlowEn` and `fifoLevel` are; a threshold of exactly 4 is enabled.
- R7: With `hwFlowEn`=0, `rtsPinN` equals the inverse of `swRtsReq` one cycle later, independent of `fifoLevel`.
- R8: `flowTrig` follows the fill comparison in manual mode too; it does not depend on `hwFlowEn`.
- R9: The fill input covers a completely full FIFO (64 entries), and the maximum threshold of 63 works in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoLevel | input | 7 | Current receive FIFO occupancy, 0 to 64 |
| flowThresh | input | 6 | Flow-delay threshold; values below 4 disable the mechanism |
| hwFlowEn | input | 1 | 1 selects hardware flow control, 0 selects manual |
| swRtsReq | input | 1 | Software request-to-send, 1 = request |
| rtsPinN | output | 1 | Request-to-send pin, active low |
| flowTrig | output | 1 | Flow-delay trigger status, registered |

## Verification
The hardest state to reach is the hold band, where the fill sits strictly between the release point and the threshold. There the pin's value depends on history, not on the present inputs. The stimulus approaches that band from both sides: it drains from a full FIFO into the band and fills from an empty one into it. This shows the pin holds whichever state it had. The bench also moves the threshold across the enable boundary at 3 and 4 while the fill and software bit disagree. This separates disabled behaviour from flow-control behaviour.

// File: rtl/rx_flow_rts_pkg.sv
package rx_flow_rts_pkg;

  // Comparison results produced by the datapath each cycle
  typedef struct packed {
    logic enabled;       // threshold large enough to arm flow delay
    logic atThresh;      // fill has reached the threshold
    logic belowRelease;  // fill is at or under threshold minus hysteresis
  } fillFlags_t;

  // Strobes from control into the datapath registers
  typedef struct packed {
    logic trigNext;  // next value of the trigger register
    logic rtsLoad;   // update the request register this cycle
    logic rtsVal;    // value to load (1 = request granted)
  } rtsStrobes_t;

endpackage

// File: rtl/rx_flow_rts_dp.sv
module rx_flow_rts_dp
  import rx_flow_rts_pkg::*;
#(
  parameter int LEVEL_W = 7,
  parameter int THR_W   = 6,
  parameter int HYST    = 4,
  parameter int MIN_THR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0]   flowThresh,
  input  rtsStrobes_t        strobes,
  output fillFlags_t         flags,
  output logic               rtsQ,
  output logic               trigQ
);

  localparam int CMP_W = ((LEVEL_W > THR_W) ? LEVEL_W : THR_W) + 2;

  logic [CMP_W-1:0] levelWide;
  logic [CMP_W-1:0] threshWide;

  assign levelWide  = CMP_W'(fifoLevel);
  assign threshWide = CMP_W'(flowThresh);

  always_comb begin
    flags.enabled      = threshWide >= CMP_W'(MIN_THR);
    flags.atThresh     = levelWide >= threshWide;
    flags.belowRelease = (levelWide + CMP_W'(HYST)) <= threshWide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsQ  <= 1'b0;
      trigQ <= 1'b0;
    end else begin
      trigQ <= strobes.trigNext;
      if (strobes.rtsLoad) rtsQ <= strobes.rtsVal;
    end
  end

endmodule

// File: rtl/rx_flow_rts_ctl.sv
module rx_flow_rts_ctl
  import rx_flow_rts_pkg::*;
(
  input  fillFlags_t  flags,
  input  logic        hwFlowEn,
  input  logic        swRtsReq,
  output rtsStrobes_t strobes
);

  logic autoMode;

  assign autoMode = hwFlowEn && flags.enabled;

  always_comb begin
    strobes.trigNext = flags.enabled && flags.atThresh;
    strobes.rtsLoad  = 1'b1;
    strobes.rtsVal   = swRtsReq;
    if (autoMode) begin
      if (flags.atThresh) begin
        strobes.rtsVal = 1'b0;
      end else if (flags.belowRelease) begin
        strobes.rtsVal = 1'b1;
      end else begin
        strobes.rtsLoad = 1'b0;
        strobes.rtsVal  = 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_flow_rts.sv
module rx_flow_rts
  import rx_flow_rts_pkg::*;
#(
  parameter int LEVEL_W = 7,
  parameter int THR_W   = 6,
  parameter int HYST    = 4,
  parameter int MIN_THR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0]   flowThresh,
  input  logic               hwFlowEn,
  input  logic               swRtsReq,
  output logic               rtsPinN,
  output logic               flowTrig
);

  fillFlags_t  flags;
  rtsStrobes_t strobes;
  logic        rtsQ;
  logic        trigQ;

  rx_flow_rts_dp #(
    .LEVEL_W(LEVEL_W), .THR_W(THR_W), .HYST(HYST), .MIN_THR(MIN_THR)
  ) uDp (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .flowThresh(flowThresh),
    .strobes(strobes), .flags(flags), .rtsQ(rtsQ), .trigQ(trigQ)
  );

  rx_flow_rts_ctl uCtl (
    .flags(flags), .hwFlowEn(hwFlowEn), .swRtsReq(swRtsReq), .strobes(strobes)
  );

  assign rtsPinN  = ~rtsQ;
  assign flowTrig = trigQ;

  AST_TRIG_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !flags.enabled |=> !flowTrig); // R6
  AST_TRIG_ON_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (flags.enabled && flags.atThresh) |=> flowTrig); // R2
  AST_RTS_WITHDRAW: assert property (@(posedge clk) disable iff (!rstN)
    (hwFlowEn && flags.enabled && flags.atThresh) |=> rtsPinN); // R3
  AST_RTS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (hwFlowEn && flags.enabled && flags.belowRelease) |=> !rtsPinN); // R4
  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hwFlowEn && flags.enabled && !flags.atThresh && !flags.belowRelease)
    |=> $stable(rtsPinN)); // R5
  AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rstN)
    !(hwFlowEn && flags.enabled) |=> (rtsPinN == !$past(swRtsReq))); // R7

endmodule

// File: tb/tb_rx_flow_rts.sv
module tb_rx_flow_rts;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] fifoLevel = '0;
  logic [5:0] flowThresh = '0;
  logic       hwFlowEn = 1'b0;
  logic       swRtsReq = 1'b0;
  logic       rtsPinN;
  logic       flowTrig;

  int checks = 0;
  int bad = 0;
  bit modelRts = 1'b0;
  bit driveDone = 1'b0;

  typedef struct {
    bit    expPinN;
    bit    expTrig;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  rx_flow_rts dut (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .flowThresh(flowThresh),
    .hwFlowEn(hwFlowEn), .swRtsReq(swRtsReq), .rtsPinN(rtsPinN), .flowTrig(flowTrig)
  );

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge and predict the registered result
  task automatic step(input int lvl, input int thr, input bit fcm, input bit sw, input string tag);
    expItem_t it;
    bit en;
    @(negedge clk);
    fifoLevel  = 7'(lvl);
    flowThresh = 6'(thr);
    hwFlowEn   = fcm;
    swRtsReq   = sw;
    en = (thr >= 4);
    if (!(fcm && en)) modelRts = sw;
    else if (lvl >= thr) modelRts = 1'b0;
    else if (lvl + 4 <= thr) modelRts = 1'b1;
    it.expPinN = !modelRts;
    it.expTrig = en && (lvl >= thr);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, "rtsPinN", rtsPinN, it.expPinN);
        check(it.tag, "flowTrig", flowTrig, it.expTrig);
      end
    end
  end

  initial begin
    #20000;
    bad++;
    checks++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    fifoLevel = 7'd60; flowThresh = 6'd10; hwFlowEn = 1'b1; swRtsReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "rtsPinN in reset", rtsPinN, 1'b1);
    check("R1", "flowTrig in reset", flowTrig, 1'b0);
    fifoLevel = '0; flowThresh = '0; hwFlowEn = 1'b0; swRtsReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "rtsPinN after reset", rtsPinN, 1'b1);
    check("R1", "flowTrig after reset", flowTrig, 1'b0);
    modelRts = 1'b0;

    step(0, 16, 0, 1, "R7");
    step(50, 16, 0, 1, "R7");
    step(50, 16, 0, 0, "R8");
    step(2, 16, 0, 0, "R7");
    step(0, 16, 1, 0, "R4");
    step(13, 16, 1, 0, "R5");
    step(15, 16, 1, 1, "R5");
    step(16, 16, 1, 1, "R3");
    step(14, 16, 1, 1, "R5");
    step(13, 16, 1, 0, "R5");
    step(12, 16, 1, 0, "R4");
    step(20, 16, 1, 0, "R2");
    step(8, 16, 1, 0, "R2");
    step(40, 3, 1, 0, "R6");
    step(40, 3, 1, 1, "R6");
    step(0, 0, 1, 0, "R6");
    step(4, 4, 1, 1, "R6");
    step(1, 4, 1, 0, "R5");
    step(0, 4, 1, 0, "R4");
    step(64, 63, 1, 0, "R9");
    step(62, 63, 1, 1, "R9");
    step(59, 63, 1, 0, "R9");
    step(63, 63, 0, 1, "R9");
    @(negedge clk);
    @(negedge clk);
    driveDone = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule